// File: doc/BRIEF.md
# Four-Lane Run-Length Byte Encoder

This block turns a stream of 4-bit samples, one per input strobe, into a compact byte stream for a serial link that must stay text-safe. Consecutive equal samples form a run. Each closed run is sent as one short token, which carries the sample value and up to seven extra repeats. It is followed, when the run holds eight or more extra repeats, by long tokens that each add a multiple of eight repeats of that same value. Every token is one byte. Short tokens always have bit 7 set, and long tokens fall in 0x30..0x7F, so no ASCII control byte is ever produced.

A run closes when a different value arrives, when the flush input is pulsed, or when the run already holds the maximum repeat count. A closed run is handed to a one-run output slot that drains through a valid/ready byte port. The port follows the usual rules. A byte moves on a clock edge where `tok_valid` and `tok_ready` are both high. Once `tok_valid` is raised, it and `tok_data` hold until that transfer. The sample input has no back-pressure. While the sink stalls, new samples keep counting into the open run. Data is lost only if a second run closes while the slot still holds bytes. That event raises a sticky overflow flag and drops the newly closed run.

Top module: `rle4_encoder`

## Requirements
- R1: After reset, `tok_valid` and `overflow` are low, and no token appears until a run closes.
- R2: Every closed run of value v with r extra repeats first yields the short token 0x80 | (r mod 8) << 4 | v, with v in bits 3:0 and the repeat count in bits 6:4.
- R3: When r is 8 or more, the short token is followed by long tokens for r minus (r mod 8), each of size s (a multiple of 8, at most 640, largest first) coded as 0x30 + s/8 − 1.
- R4: A strobe whose value differs from the open run closes that run, and the new value opens a run with zero repeats.
- R5: A flush closes the open run. A flush with no open run emits nothing. A flush in the same cycle as a strobe closes the run as it stood before that strobe, and the strobed sample then opens a new run.
- R6: A run holds at most MAX_REP (640) extra repeats. A further equal sample closes it and opens a new run of the same value with zero repeats.
- R7: While `tok_valid` is high and `tok_ready` is low, `tok_valid` stays high and `tok_data` stays unchanged on the next cycle.
- R8: While `tok_ready` is low, strobed samples keep accumulating in the open run. No data is lost and `overflow` stays low as long as at most one closed run is waiting.
- R9: If a run closes while the slot still holds unsent bytes of the previous run, `overflow` goes high and stays high until reset. The newly closed run is discarded.
- R10: Every byte offered on `tok_data` is at least 0x30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe, one sample per high cycle |
| smp_val | input | 4 | Sample value |
| flush | input | 1 | Close the open run |
| tok_valid | output | 1 | Token byte available |
| tok_data | output | 8 | Token byte |
| tok_ready | input | 1 | Sink accepts the token byte |
| overflow | output | 1 | Sticky loss flag |

## Verification
Two states are hard to reach from the ports. The first is the repeat cap. It only triggers after 641 equal samples, so the vector table has runs of 641, 642 and 648 samples, spaced so the slot drains between closures. The second is a run closing while the slot is still occupied. The sink is held stalled while three distinct values are strobed, which closes a second run behind an unsent one. The test then checks that the flag sets and that only the surviving runs reach the output. A separate stalled case closes exactly one run and keeps counting the next. It shows that the held byte stays stable and that no loss is reported.

// File: rtl/rle4_pkg.sv
package rle4_pkg;
  localparam int SMP_W       = 4;
  localparam int TOK_W       = 8;
  localparam int SHORT_REP_W = 3;
  localparam int LONG_UNIT   = 8;
  localparam int LONG_MAX    = 640;
  localparam logic [TOK_W-1:0] LONG_BASE = 8'h30;

  function automatic logic [TOK_W-1:0] short_token(
    input logic [SMP_W-1:0] v, input logic [SHORT_REP_W-1:0] rep);
    return {1'b1, rep, v};
  endfunction

  function automatic logic [TOK_W-1:0] long_token(input logic [TOK_W-1:0] units);
    return LONG_BASE + units - 8'd1;
  endfunction
endpackage

// File: rtl/rle4_run_tracker.sv
module rle4_run_tracker
  import rle4_pkg::*;
#(
  parameter int MAX_REP = 640,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_val,
  input  logic             flush,
  input  logic             slot_accept,
  output logic             close_valid,
  output logic [SMP_W-1:0] close_val,
  output logic [CNT_W-1:0] close_rep,
  output logic             overflow
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_REP);

  logic             active;
  logic [SMP_W-1:0] cur;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             breaks_run;

  always_comb begin
    breaks_run  = smp_valid && (smp_val != cur || cnt == CAP);
    close_valid = active && (flush || breaks_run);
    close_val   = cur;
    close_rep   = cnt;
    overflow    = ovf;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cur    <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      if (smp_valid) begin
        if (close_valid || !active) begin
          cur    <= smp_val;
          cnt    <= '0;
          active <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (flush) begin
        active <= 1'b0;
      end
      if (close_valid && !slot_accept) ovf <= 1'b1;
    end
  end

  // R9: loss flag never clears outside reset
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R6: a closed run never exceeds the repeat cap
  assert_rep_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid |-> close_rep <= CAP);
endmodule

// File: rtl/rle4_token_emitter.sv
module rle4_token_emitter
  import rle4_pkg::*;
#(
  parameter int MAX_REP = 640,
  parameter int CNT_W   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SMP_W-1:0] load_val,
  input  logic [CNT_W-1:0] load_rep,
  output logic             accept,
  output logic             tok_valid,
  output logic [TOK_W-1:0] tok_data,
  input  logic             tok_ready
);
  localparam int CHUNK_MAX = ((MAX_REP < LONG_MAX ? MAX_REP : LONG_MAX) / LONG_UNIT) * LONG_UNIT;
  localparam logic [CNT_W-1:0] CHUNK_CAP = CNT_W'(CHUNK_MAX);

  logic                   full;
  logic                   short_done;
  logic [SMP_W-1:0]       val;
  logic [SHORT_REP_W-1:0] rep_lo;
  logic [CNT_W-1:0]       rem;
  logic [CNT_W-1:0]       chunk;
  logic                   fire;
  logic                   last;

  always_comb begin
    chunk     = (rem > CHUNK_CAP) ? CHUNK_CAP : rem;
    tok_valid = full;
    tok_data  = short_done ? long_token(TOK_W'(chunk >> 3)) : short_token(val, rep_lo);
    fire      = full && tok_ready;
    last      = short_done ? (rem == chunk) : (rem == '0);
    accept    = !full || (fire && last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full       <= 1'b0;
      short_done <= 1'b0;
      val        <= '0;
      rep_lo     <= '0;
      rem        <= '0;
    end else if (load && accept) begin
      full       <= 1'b1;
      short_done <= 1'b0;
      val        <= load_val;
      rep_lo     <= load_rep[SHORT_REP_W-1:0];
      rem        <= {load_rep[CNT_W-1:SHORT_REP_W], {SHORT_REP_W{1'b0}}};
    end else if (fire) begin
      if (last) full <= 1'b0;
      else if (!short_done) short_done <= 1'b1;
      else rem <= rem - chunk;
    end
  end

  // R7: stalled byte is held
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && !tok_ready) |=> (tok_valid && $stable(tok_data)));
  // R10: no control bytes offered
  assert_byte_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> tok_data >= 8'h30);
  // R2: output that starts from idle begins with a short token
  assert_short_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tok_valid) |-> tok_data[7]);
endmodule

// File: rtl/rle4_encoder.sv
module rle4_encoder
  import rle4_pkg::*;
#(
  parameter int MAX_REP = 640
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_valid,
  input  logic [3:0] smp_val,
  input  logic       flush,
  output logic       tok_valid,
  output logic [7:0] tok_data,
  input  logic       tok_ready,
  output logic       overflow
);
  localparam int CNT_W = $clog2(MAX_REP + 1);

  logic             close_valid;
  logic [SMP_W-1:0] close_val;
  logic [CNT_W-1:0] close_rep;
  logic             slot_accept;

  rle4_run_tracker #(.MAX_REP(MAX_REP), .CNT_W(CNT_W)) u_tracker (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_val(smp_val),
    .flush(flush), .slot_accept(slot_accept), .close_valid(close_valid),
    .close_val(close_val), .close_rep(close_rep), .overflow(overflow)
  );

  rle4_token_emitter #(.MAX_REP(MAX_REP), .CNT_W(CNT_W)) u_emitter (
    .clk(clk), .rst_n(rst_n), .load(close_valid), .load_val(close_val),
    .load_rep(close_rep), .accept(slot_accept), .tok_valid(tok_valid),
    .tok_data(tok_data), .tok_ready(tok_ready)
  );

  // R1: nothing offered in the cycle right after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!tok_valid && !overflow));
endmodule

// File: tb/rle4_encoder_test.sv
module rle4_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {value[15:12], sample count[11:0]}
  localparam logic [15:0] VEC [0:NVEC-1] = '{
    16'hA001, 16'h3002, 16'h5008, 16'h9009, 16'hF015,
    16'h0281, 16'h7282, 16'h2011, 16'h6001, 16'hC288 };

  logic clk = 0, rst_n = 0, smp_valid = 0, flush = 0, tok_ready = 1;
  logic [3:0] smp_val = 0;
  logic tok_valid, overflow;
  logic [7:0] tok_data;

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] got [0:63];
  logic [7:0] exp_b [0:63];
  int got_n = 0, exp_n = 0;

  rle4_encoder uut (.clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_val(smp_val),
    .flush(flush), .tok_valid(tok_valid), .tok_data(tok_data), .tok_ready(tok_ready),
    .overflow(overflow));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk)
    if (rst_n && tok_valid && tok_ready && got_n < 64) begin
      got[got_n] = tok_data;
      got_n = got_n + 1;
    end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000 cycles", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(posedge clk); #1; rst_n = 0;
    cycles(3);
    rst_n = 1;
    got_n = 0; exp_n = 0;
  endtask

  task automatic strobe(input logic [3:0] v, input bit fl);
    @(posedge clk); #1; smp_valid = 1; smp_val = v; flush = fl;
    @(posedge clk); #1; smp_valid = 0; flush = 0;
  endtask

  task automatic do_flush();
    @(posedge clk); #1; flush = 1;
    @(posedge clk); #1; flush = 0;
  endtask

  // spec model for one closed run: value v, r extra repeats (R2, R3)
  task automatic add_run(input logic [3:0] v, input int r);
    int rem;
    exp_b[exp_n] = 8'h80 | 8'((r % 8) << 4) | {4'h0, v};
    exp_n++;
    rem = r - (r % 8);
    while (rem > 0) begin
      int ch;
      ch = (rem > 640) ? 640 : rem;
      exp_b[exp_n] = 8'(8'h30 + ch / 8 - 1);
      exp_n++;
      rem -= ch;
    end
  endtask

  // R6: a stretch of equal samples splits every 641 samples
  task automatic add_samples(input logic [3:0] v, input int len);
    while (len > 0) begin
      int n;
      n = (len > 641) ? 641 : len;
      add_run(v, n - 1);
      len -= n;
    end
  endtask

  task automatic compare(input string req);
    check(got_n == exp_n, {req, " token count"}, got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      check(got[i] == exp_b[i], req, got[i], exp_b[i]);
  endtask

  initial begin
    do_reset();
    // R1 reset state
    check(tok_valid == 0, "R1 tok_valid", tok_valid, 0);
    check(overflow == 0, "R1 overflow", overflow, 0);

    // R5 flush with no open run emits nothing
    do_flush();
    cycles(4);
    check(got_n == 0 && !tok_valid, "R5 idle flush", got_n, 0);

    // Vector table: R2 R3 R4 R6 R10, sink always ready
    for (int k = 0; k < NVEC; k++) begin
      logic [3:0] v;
      int len;
      v = VEC[k][15:12];
      len = int'(VEC[k][11:0]);
      add_samples(v, len);
      for (int j = 0; j < len; j++) strobe(v, 1'b0);
    end
    do_flush();
    cycles(8);
    compare("R2 R3 R4 R6 table");
    for (int i = 0; i < got_n; i++)
      check(got[i] >= 8'h30, "R10 byte range", got[i], 8'h30);
    check(overflow == 0, "R8 no loss in table", overflow, 0);

    // R7 R8 back-pressure with one run waiting
    do_reset();
    tok_ready = 0;
    for (int j = 0; j < 5; j++) strobe(4'h5, 1'b0);
    for (int j = 0; j < 12; j++) strobe(4'hA, 1'b0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check(tok_valid == 1 && tok_data == 8'hC5, "R7 held byte", tok_data, 8'hC5);
    end
    check(overflow == 0, "R8 no overflow while stalled", overflow, 0);
    tok_ready = 1;
    cycles(4);
    do_flush();
    cycles(6);
    add_run(4'h5, 4);
    add_run(4'hA, 11);
    compare("R8 stalled stream");

    // R9 overflow: second run closes behind an unsent one
    do_reset();
    tok_ready = 0;
    strobe(4'h1, 1'b0);
    strobe(4'h2, 1'b0);
    strobe(4'h3, 1'b0);
    cycles(1);
    check(overflow == 1, "R9 overflow set", overflow, 1);
    tok_ready = 1;
    cycles(4);
    do_flush();
    cycles(6);
    add_run(4'h1, 0);
    add_run(4'h3, 0);
    compare("R9 dropped run");
    check(overflow == 1, "R9 sticky", overflow, 1);

    // R1 reset clears the flag again
    do_reset();
    check(overflow == 0 && tok_valid == 0, "R1 reset clears", overflow, 0);

    // R5 flush together with a strobe
    for (int j = 0; j < 3; j++) strobe(4'h4, 1'b0);
    strobe(4'h4, 1'b1);
    cycles(3);
    do_flush();
    cycles(6);
    add_run(4'h4, 2);
    add_run(4'h4, 0);
    compare("R5 flush with strobe");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule